// File: doc/BRIEF.md
# Bit-Parallel Distributed-Arithmetic FIR Filter

This block is a constant-coefficient FIR filter that needs no general-purpose multiplier. Each new signed sample enters a tap delay line. For every bit position of the samples there is a separate combination table. Its address is made of that bit taken from every tap, and its result is the sum of the coefficients whose address bit is set. The results for all bit positions are produced in the same cycle. Each one is weighted by its power of two, and the result for the two's-complement sign position is negated. A tree of registered adders then sums them.

The block has one streaming input and one streaming output, each with a valid flag. A full result is produced on every clock, so samples can arrive back to back. The output valid flag is the input valid flag delayed by a fixed number of cycles. The coefficients are a build-time parameter. The output keeps full precision, so it cannot overflow.

Top module: `dafir_par`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line and every pipeline register. On the clock edge after reset is sampled high, `out_valid` is 0 and `out_data` is 0.
- R2: A result equals sum over k=0..14 of c[k]*x[k]. Here x[0] is the most recent accepted sample, x[k] is the sample accepted k acceptances earlier, and taps that have not yet been filled count as 0. With default parameters the coefficients c[0]..c[14] are -512, -12, 0, 31, -64, 0, 203, 511, 203, 0, -64, 31, 0, -12, 7.
- R3: Samples are 8-bit two's complement, including -128 and 127. `out_data` is a 22-bit two's-complement value that equals R2 exactly for every input sequence, including runs of extreme values.
- R4: When `in_valid` is 1 at clock edge n, `out_valid` is 1 right after edge n+4, and the matching result is on `out_data`. Consecutive valid samples give consecutive valid results, one per clock.
- R5: A sample presented with `in_valid` at 0 is not accepted: the delay line does not move. The result for the next accepted sample is the same as if the invalid cycle had never happened.
- R6: After edge n+4, `out_valid` repeats the `in_valid` value of edge n, including 0. While no samples are accepted, `out_data` keeps showing the filter of the held delay line, so it stays constant once the pipeline has drained.
- R7: The table for the sign bit is subtracted, not added. A single -128 followed by zeros gives the impulse response -128*c[k]. A single 127 followed by zeros gives 127*c[k].
- R8: A reset asserted while samples are in flight discards them. No result for a sample accepted before that reset edge appears after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The sample on `in_data` is accepted this cycle |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | `out_data` holds the result for an accepted sample |
| out_data | output | 22 | Signed full-precision filter result |

## Verification
The assertions assume three things about the inputs. Reset is high on the first clock edge. `in_valid` and `in_data` carry known values whenever reset is low. A check that looks back over a window is only valid once that many non-reset cycles have passed since the last reset, and counters enforce this. The zero-flush property also needs an unbroken run of accepted zeros longer than the tap count plus the latency, so it is idle unless the stimulus supplies such a run. The bench holds reset from time zero and drives every input from a known value on the falling half of the clock. It only deasserts reset once the first edges have cleared the pipeline. It applies reset mid-stream on a clock edge, exactly as it does at start-up.

// File: rtl/dafir_pkg.sv
`timescale 1ns/1ps
package dafir_pkg;

    localparam int DEF_TAPS = 15;
    localparam int DEF_SW   = 8;
    localparam int DEF_CW   = 10;

    // default coefficient set, index 0 multiplies the newest sample
    function automatic int def_coef(input int k);
        case (k)
            0:  return -512;
            1:  return -12;
            2:  return 0;
            3:  return 31;
            4:  return -64;
            5:  return 0;
            6:  return 203;
            7:  return 511;
            8:  return 203;
            9:  return 0;
            10: return -64;
            11: return 31;
            12: return 0;
            13: return -12;
            14: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic [DEF_TAPS*DEF_CW-1:0] pack_def_coefs();
        logic [DEF_TAPS*DEF_CW-1:0] v;
        v = '0;
        for (int k = 0; k < DEF_TAPS; k++)
            v[k*DEF_CW +: DEF_CW] = DEF_CW'(def_coef(k));
        return v;
    endfunction

    localparam logic [DEF_TAPS*DEF_CW-1:0] DEF_COEFS = pack_def_coefs();

    // full-precision result width
    function automatic int result_width(input int sw, input int cw, input int taps);
        return sw + cw + $clog2(taps);
    endfunction

    // number of registered adder levels for a given leaf count
    function automatic int tree_levels(input int leaves);
        return (leaves <= 1) ? 1 : $clog2(leaves);
    endfunction

endpackage

// File: rtl/dafir_tapline.sv
`timescale 1ns/1ps
module dafir_tapline #(
    parameter int TAPS = 15,
    parameter int SW   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [SW-1:0]            in_data,
    output logic [SW-1:0][TAPS-1:0]  planes
);

    logic [SW-1:0] taps_q [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS; k++) taps_q[k] <= '0;
        end else if (in_valid) begin
            taps_q[0] <= in_data;
            for (int k = 1; k < TAPS; k++) taps_q[k] <= taps_q[k-1];
        end
    end

    // transpose: one address word per bit position
    for (genvar b = 0; b < SW; b++) begin : g_bit
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            assign planes[b][k] = taps_q[k][b];
        end
    end

    // R5: an invalid cycle leaves the delay line untouched
    p_hold_taps_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(planes));

endmodule

// File: rtl/dafir_plane.sv
`timescale 1ns/1ps
module dafir_plane #(
    parameter int                    TAPS  = 15,
    parameter int                    CW    = 10,
    parameter int                    OW    = 22,
    parameter int                    BIT   = 0,
    parameter bit                    NEG   = 1'b0,
    parameter logic [TAPS*CW-1:0]    COEFS = '0
) (
    input  logic [TAPS-1:0]          sel,
    output logic signed [OW-1:0]     term
);

    logic signed [OW-1:0] acc;
    logic signed [CW-1:0] cval;
    logic signed [OW-1:0] scaled;

    // combination table evaluated from the coefficient parameter
    always_comb begin
        acc  = '0;
        cval = '0;
        for (int k = 0; k < TAPS; k++) begin
            cval = COEFS[k*CW +: CW];
            if (sel[k]) acc = acc + OW'(cval);
        end
    end

    assign scaled = acc <<< BIT;

    if (NEG) begin : g_sign
        assign term = -scaled;
    end else begin : g_mag
        assign term = scaled;
    end

endmodule

// File: rtl/dafir_tree.sv
`timescale 1ns/1ps
module dafir_tree #(
    parameter int LEAVES = 8,
    parameter int OW     = 22
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [OW-1:0]  leaf_in [LEAVES],
    output logic signed [OW-1:0]  sum
);

    localparam int LEVELS = dafir_pkg::tree_levels(LEAVES);
    localparam int NLEAF  = 1 << LEVELS;

    logic signed [OW-1:0] leaf_ext [NLEAF];
    // heap layout: node i sums nodes 2i and 2i+1, leaves at NLEAF..2*NLEAF-1
    logic signed [OW-1:0] node_q [1:2*NLEAF-1];

    for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
        if (j < LEAVES) begin : g_used
            assign leaf_ext[j] = leaf_in[j];
        end else begin : g_pad
            assign leaf_ext[j] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i < 2*NLEAF; i++) node_q[i] <= '0;
        end else begin
            for (int i = 1; i < NLEAF; i++) node_q[i] <= node_q[2*i] + node_q[2*i+1];
            for (int j = 0; j < NLEAF; j++) node_q[NLEAF+j] <= leaf_ext[j];
        end
    end

    assign sum = node_q[1];

endmodule

// File: rtl/dafir_par.sv
`timescale 1ns/1ps
module dafir_par #(
    parameter int                  TAPS  = dafir_pkg::DEF_TAPS,
    parameter int                  SW    = dafir_pkg::DEF_SW,
    parameter int                  CW    = dafir_pkg::DEF_CW,
    parameter logic [TAPS*CW-1:0]  COEFS = dafir_pkg::DEF_COEFS
) (
    input  logic                                                     clk,
    input  logic                                                     rst,
    input  logic                                                     in_valid,
    input  logic signed [SW-1:0]                                     in_data,
    output logic                                                     out_valid,
    output logic signed [dafir_pkg::result_width(SW, CW, TAPS)-1:0]  out_data
);

    localparam int OW     = dafir_pkg::result_width(SW, CW, TAPS);
    localparam int LEVELS = dafir_pkg::tree_levels(SW);
    localparam int LAT    = LEVELS + 1;
    localparam int ZLIM   = TAPS + LAT + 1;
    localparam int ZW     = $clog2(ZLIM + 1) + 1;
    localparam int LW     = $clog2(LAT + 3) + 1;

    logic [SW-1:0][TAPS-1:0] planes;
    logic signed [OW-1:0]    terms [SW];
    logic [LAT:0]            vld_q;

    dafir_tapline #(.TAPS(TAPS), .SW(SW)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .planes   (planes)
    );

    for (genvar b = 0; b < SW; b++) begin : g_plane
        dafir_plane #(
            .TAPS  (TAPS),
            .CW    (CW),
            .OW    (OW),
            .BIT   (b),
            .NEG   (b == SW - 1),
            .COEFS (COEFS)
        ) u_table (
            .sel  (planes[b]),
            .term (terms[b])
        );
    end

    dafir_tree #(.LEAVES(SW), .OW(OW)) u_tree (
        .clk     (clk),
        .rst     (rst),
        .leaf_in (terms),
        .sum     (out_data)
    );

    // valid flag travels alongside the data: tap stage plus tree stages
    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[LAT-1:0], in_valid};
    end

    assign out_valid = vld_q[LAT];

    // ---------------- assertion support counters ----------------
    logic [LW-1:0] since_q;
    logic [LW-1:0] idle_q;
    logic [ZW-1:0] zero_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            idle_q  <= '0;
            zero_q  <= '0;
        end else begin
            if (since_q <= LW'(LAT)) since_q <= since_q + 1'b1;
            if (in_valid)                   idle_q <= '0;
            else if (idle_q <= LW'(LAT + 1)) idle_q <= idle_q + 1'b1;
            if (!in_valid || in_data != '0)  zero_q <= '0;
            else if (zero_q < ZW'(ZLIM))     zero_q <= zero_q + 1'b1;
        end
    end

    // R4: output valid is the input valid delayed by the pipeline depth
    p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (since_q > LW'(LAT)) |-> (out_valid == $past(in_valid, LAT + 1)));

    // R6: a drained pipeline with nothing accepted holds its result
    p_idle_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (idle_q >= LW'(LAT + 2)) |-> $stable(out_data));

    // R2: a window of accepted zeros flushes the result to zero
    p_zero_flush_r2: assert property (@(posedge clk) disable iff (rst)
        (zero_q >= ZW'(ZLIM)) |-> (out_data == '0));

endmodule

// File: tb/dafir_par_test.sv
`timescale 1ns/1ps
module dafir_par_test;

    localparam int TAPS = 15;
    localparam int SW   = 8;
    localparam int OW   = 22;
    localparam int LAT  = 4;
    localparam int COEF [TAPS] = '{-512, -12, 0, 31, -64, 0, 203, 511, 203, 0, -64, 31, 0, -12, 7};

    function automatic logic [11:0] mk(input bit v, input int t, input int d);
        return {v, 3'(t), 8'(d)};
    endfunction

    // {valid, requirement selector, sample}
    localparam int NVEC = 36;
    localparam logic [11:0] VEC [NVEC] = '{
        mk(1,7,-128), mk(1,7,0), mk(1,7,0), mk(1,7,0), mk(1,7,0), mk(1,7,0), mk(1,7,0),
        mk(1,7,127),  mk(1,7,0), mk(1,7,0), mk(1,7,0), mk(1,7,0), mk(1,7,0),
        mk(1,3,-128), mk(1,3,127), mk(1,3,-128), mk(1,3,-128), mk(1,3,127),
        mk(1,3,-128), mk(1,3,127), mk(1,3,127), mk(1,3,-128), mk(1,3,127),
        mk(1,3,-128), mk(1,3,-128), mk(1,3,127), mk(1,3,127), mk(1,3,-128),
        mk(0,5,55),   mk(1,5,9),   mk(0,5,-3),   mk(0,5,77),   mk(1,5,-40),
        mk(0,5,127),  mk(1,5,1),   mk(0,5,-128)
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [SW-1:0] in_data = '0;
    logic out_valid;
    logic signed [OW-1:0] out_data;

    always #2.5 clk = ~clk;

    dafir_par uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int     hist [TAPS];
    bit     pv   [LAT+1];
    longint pd   [LAT+1];
    int     n_chk = 0;
    int     n_bad = 0;

    function automatic longint conv();
        longint s = 0;
        for (int k = 0; k < TAPS; k++) s += longint'(COEF[k]) * longint'(hist[k]);
        return s;
    endfunction

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // apply one cycle, advance the reference, compare outputs after the edge
    task automatic step(input bit r, input bit v, input int d, input string tag);
        rst      = r;
        in_valid = v;
        in_data  = d[SW-1:0];
        @(posedge clk);
        #1;
        if (r) begin
            for (int k = 0; k < TAPS; k++) hist[k] = 0;
            for (int i = 0; i <= LAT; i++) begin pv[i] = 1'b0; pd[i] = 0; end
        end else begin
            for (int i = LAT; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; end
            if (v) begin
                for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = d;
            end
            pv[0] = v;
            pd[0] = conv();
        end
        n_chk++;
        if (out_valid !== pv[LAT] || out_data !== OW'(pd[LAT])) begin
            n_bad++;
            $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                     tag, out_valid, out_data, pv[LAT], pd[LAT]);
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL R4 watchdog: run still active, expected completion");
        report();
        $finish;
    end

    initial begin
        logic signed [SW-1:0] r8;
        string tag;

        // R1: reset from time zero clears outputs
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, "R1");

        // table of directed vectors
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][10:8])
                3'd3:    tag = "R3";
                3'd5:    tag = "R5";
                3'd7:    tag = "R7";
                default: tag = "R2";
            endcase
            step(1'b0, VEC[i][11], int'($signed(VEC[i][7:0])), tag);
        end

        // R6: long idle stretch, result held and valid low
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 33, "R6");

        // R4: back-to-back random samples
        for (int i = 0; i < 300; i++) begin
            r8 = SW'($urandom);
            step(1'b0, 1'b1, int'(r8), "R4");
        end

        // R2: random samples with random gaps
        for (int i = 0; i < 300; i++) begin
            r8 = SW'($urandom);
            step(1'b0, ($urandom % 4) != 0, int'(r8), "R2");
        end

        // R2: accepted zeros flush the window
        for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 0, "R2");

        // R8: reset in the middle of a busy stream
        for (int i = 0; i < 6; i++) begin
            r8 = SW'($urandom);
            step(1'b0, 1'b1, int'(r8), "R8");
        end
        step(1'b1, 1'b1, 99, "R8");
        for (int i = 0; i < LAT + 4; i++) step(1'b0, 1'b0, 0, "R8");
        for (int i = 0; i < 20; i++) begin
            r8 = SW'($urandom);
            step(1'b0, 1'b1, int'(r8), "R8");
        end
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, 0, "R6");

        report();
        $finish;
    end

endmodule